// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Sequencer

This block times one programmed-I/O transfer on a parallel IDE/ATA device bus. The host issues a request that names the target device (master or slave), the direction and the width (16-bit or 8-bit). The block then walks through three phases:

- **Address setup.** Chip-select and the register address are held steady before any strobe.
- **Active.** The read or write strobe is held low.
- **Recovery.** The strobe is high again while chip-select stays asserted.

Each phase lasts a programmable number of bus clocks. On a read, the block captures the device's data bus at the end of the active phase. It then reports completion with a one-clock done pulse.

Software programs the timing through a byte-wide register-write port with a per-bit write mask. Each device owns the following timing values:

- an address-setup nibble;
- a byte for 16-bit reads;
- a byte for 16-bit writes;
- a byte shared by all 8-bit accesses.

Every stored count means one clock more than its value, so a phase is never zero clocks long. The timing for a transfer is frozen when its request is accepted. A register write made while a transfer is running only affects later transfers.

Top module: `ide_pio_seq`

## Requirements
- R1: After reset every timing field holds 0xF. The sequencer is idle with `busy`=0 and `done`=0, `ide_cs_n`, `ide_dior_n` and `ide_diow_n` are all 1, and `ide_dd_oe`=0.
- R2: Register writes use the following map (`cfg_addr`, hex):
  - 0x48: address setup, master in bits [3:0], slave in bits [7:4].
  - 0x4C: master 16-bit read.
  - 0x4D: master 16-bit write.
  - 0x4E: slave 16-bit read.
  - 0x4F: slave 16-bit write.
  - 0x50: master 8-bit.
  - 0x51: slave 8-bit.

  In an access byte, bits [7:4] are the active count and bits [3:0] the recovery count. Only the bits whose `cfg_wmask` bit is 1 change. Writes to any other address change nothing.
- R3: `req_dev` (0 = master, 1 = slave) selects the timing set. A 16-bit read uses the read byte, a 16-bit write uses the write byte, and any access with `req_byte`=1 uses the 8-bit byte.
- R4: A stored field N gives a phase of N+1 clocks. There are setup+1 clocks with `ide_cs_n`=0 and both strobes high, then active+1 clocks with the selected strobe low, then recovery+1 clocks with `ide_cs_n`=0 and both strobes high. The other strobe is never low.
- R5: On a read, `rd_data` takes `ide_dd_in` as sampled at the clock edge that ends the active phase. For an 8-bit read, `rd_data[15:8]` is 0.
- R6: On a write, `ide_dd_oe` is 1 from the first setup clock through the last active clock and 0 in recovery. While it is 1, `ide_dd_out` equals `req_wdata`, with the upper byte forced to 0 for an 8-bit write.
- R7: `busy` is 1 from the clock after acceptance through the last recovery clock. `done` is 1 for exactly the one clock after recovery ends.
- R8: A request is accepted only while idle. A `req_valid` raised while busy starts no transfer.
- R9: Timing values are captured at acceptance. A register write during a transfer changes only later transfers.
- R10: `ide_addr` holds `req_addr` of the accepted request for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_addr | input | 8 | Timing register byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_wmask | input | 8 | Per-bit write mask |
| req_valid | input | 1 | Transfer request |
| req_dev | input | 1 | Device select, 0 master, 1 slave |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 for an 8-bit transfer |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Captured read data |
| ide_addr | output | 3 | Device register address |
| ide_cs_n | output | 1 | Chip-select, active low |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Data bus drive value |
| ide_dd_oe | output | 1 | Data bus output enable |
| ide_dd_in | input | 16 | Data bus sampled value |

## Verification
The bench sweeps every field value from 0 to 15 for both devices and all four access kinds, and measures each phase length at the pins.

- **Off-by-one counts.** A design that loads N instead of N+1 would show phases one clock short.
- **Mixed-up timing bytes.** A design that swapped the read, write or 8-bit bytes, or the two devices, would show the wrong lengths.
- **Unmasked setup writes.** Each setup write covers only one nibble. A design that ignored the mask would corrupt the other device's setup time.
- **Read capture edge.** The data bus changes on every active clock, so capturing one clock early or late returns a neighbouring value.
- **Writes and requests while busy.** A request and a register write are injected mid-transfer. A design that restarted, or that applied new timing to the running transfer, shows an extra transfer or changed phase lengths.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  localparam int CNT_W  = 4;
  localparam int NREG   = 7;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
  } pio_timing_t;

  // slot 0 is the shared setup register, slots 1..6 are access bytes
  function automatic logic [7:0] slot_offset(input int slot);
    case (slot)
      0:       slot_offset = 8'h48;
      1:       slot_offset = 8'h4C;
      2:       slot_offset = 8'h4D;
      3:       slot_offset = 8'h4E;
      4:       slot_offset = 8'h4F;
      5:       slot_offset = 8'h50;
      default: slot_offset = 8'h51;
    endcase
  endfunction

  function automatic logic [7:0] masked_merge(input logic [7:0] old_v,
                                              input logic [7:0] new_v,
                                              input logic [7:0] mask);
    masked_merge = (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/ide_pio_timing_regs.sv
module ide_pio_timing_regs
  import ide_pio_pkg::*;
#(
  parameter int CFG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [7:0]        cfg_wmask,
  input  logic              sel_dev,
  input  logic              sel_write,
  input  logic              sel_byte,
  output pio_timing_t       sel_timing
);

  logic [NREG-1:0][7:0] slots;
  logic [7:0]           acc_byte;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [7:0] q;
    logic       hit;
    assign hit = cfg_we && (cfg_addr == CFG_AW'(slot_offset(g)));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= 8'hFF;
      else if (hit) q <= masked_merge(q, cfg_wdata, cfg_wmask);
    end
    assign slots[g] = q;
  end

  always_comb begin
    if (sel_byte)     acc_byte = sel_dev ? slots[6] : slots[5];
    else if (sel_dev) acc_byte = sel_write ? slots[4] : slots[3];
    else              acc_byte = sel_write ? slots[2] : slots[1];
  end

  assign sel_timing.setup = sel_dev ? slots[0][7:4] : slots[0][3:0];
  assign sel_timing.act   = acc_byte[7:4];
  assign sel_timing.rec   = acc_byte[3:0];

endmodule

// File: rtl/ide_pio_phase_fsm.sv
module ide_pio_phase_fsm
  import ide_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  pio_timing_t tm_in,
  output pio_phase_t  phase,
  output logic        phase_last,
  output logic        done_q
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] rec_q;

  assign phase_last = (phase != PH_IDLE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (phase == PH_RECOV) && phase_last;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= tm_in.setup;
          act_q <= tm_in.act;
          rec_q <= tm_in.rec;
        end
        PH_SETUP: if (phase_last) begin
          phase <= PH_ACTIVE;
          cnt   <= act_q;
        end else cnt <= cnt - 1'b1;
        PH_ACTIVE: if (phase_last) begin
          phase <= PH_RECOV;
          cnt   <= rec_q;
        end else cnt <= cnt - 1'b1;
        default: if (phase_last) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int AW     = 3,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [7:0]        cfg_wmask,
  input  logic              req_valid,
  input  logic              req_dev,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic [AW-1:0]     ide_addr,
  output logic              ide_cs_n,
  output logic              ide_dior_n,
  output logic              ide_diow_n,
  output logic [DW-1:0]     ide_dd_out,
  output logic              ide_dd_oe,
  input  logic [DW-1:0]     ide_dd_in
);

  localparam int LOW_W = DW / 2;

  pio_timing_t     req_tm;
  pio_phase_t      phase;
  logic            phase_last;
  logic            accept;
  logic            capture;
  logic            write_q;
  logic            byte_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;

  function automatic logic [DW-1:0] narrow(input logic [DW-1:0] v, input logic is_byte);
    narrow = is_byte ? {{(DW-LOW_W){1'b0}}, v[LOW_W-1:0]} : v;
  endfunction

  assign accept  = req_valid && (phase == PH_IDLE);
  assign capture = (phase == PH_ACTIVE) && phase_last && !write_q;

  ide_pio_timing_regs #(.CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_wmask(cfg_wmask), .sel_dev(req_dev),
    .sel_write(req_write), .sel_byte(req_byte), .sel_timing(req_tm)
  );

  ide_pio_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .tm_in(req_tm),
    .phase(phase), .phase_last(phase_last), .done_q(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
    end else begin
      if (accept) begin
        write_q <= req_write;
        byte_q  <= req_byte;
        addr_q  <= req_addr;
        wdata_q <= narrow(req_wdata, req_byte);
      end
      if (capture) rd_data <= narrow(ide_dd_in, byte_q);
    end
  end

  assign busy       = (phase != PH_IDLE);
  assign ide_cs_n   = (phase == PH_IDLE);
  assign ide_addr   = addr_q;
  assign ide_dior_n = !((phase == PH_ACTIVE) && !write_q);
  assign ide_diow_n = !((phase == PH_ACTIVE) && write_q);
  assign ide_dd_oe  = write_q && ((phase == PH_SETUP) || (phase == PH_ACTIVE));
  assign ide_dd_out = wdata_q;

endmodule

// File: rtl/ide_pio_seq_chk.sv
module ide_pio_seq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          accept,
  input logic          ide_cs_n,
  input logic          ide_dior_n,
  input logic          ide_diow_n,
  input logic          ide_dd_oe,
  input logic [AW-1:0] ide_addr
);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_dior_n && !ide_diow_n));

  // R4
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_dior_n || !ide_diow_n) |-> !ide_cs_n);

  // R8
  start_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

  // R8
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R6
  oe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ide_dd_oe |-> busy);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(ide_addr)));

endmodule

bind ide_pio_seq ide_pio_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .accept(accept),
  .ide_cs_n(ide_cs_n), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
  .ide_dd_oe(ide_dd_oe), .ide_addr(ide_addr)
);

// File: tb/ide_pio_seq_bench.sv
module ide_pio_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0, cfg_wmask = '0;
  logic req_valid = 1'b0, req_dev = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ide_dd_in = 16'hDEAD;
  logic busy, done, ide_cs_n, ide_dior_n, ide_diow_n, ide_dd_oe;
  logic [15:0] rd_data, ide_dd_out;
  logic [2:0] ide_addr;

  int checks = 0, errors = 0;
  logic [7:0] model [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_pio_seq u_ide_pio_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_addr_slot(input logic [7:0] a);
    case (a)
      8'h48: return 0; 8'h4C: return 1; 8'h4D: return 2; 8'h4E: return 3;
      8'h4F: return 4; 8'h50: return 5; 8'h51: return 6;
      default: return -1;
    endcase
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m);
    int s;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_wmask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    s = model_addr_slot(a);
    if (s >= 0) model[s] = (model[s] & ~m) | (d & m);
  endtask

  // poke: inject a busy-time request and a register write (new byte value pv)
  task automatic run_cycle(input bit dev, input bit wr, input bit byt,
                           input logic [2:0] a, input logic [15:0] wd,
                           input logic [15:0] base, input bit poke,
                           input logic [7:0] pa, input logic [7:0] pv);
    int es, ea, er, ns, na, nr, slot;
    logic [7:0] tb;
    logic [15:0] exp_out, exp_rd;
    bit oe_ok, addr_ok, other_ok, busy_ok;
    es = int'(dev ? model[0][7:4] : model[0][3:0]) + 1;
    slot = byt ? (dev ? 6 : 5) : (dev ? (wr ? 4 : 3) : (wr ? 2 : 1));
    tb = model[slot];
    ea = int'(tb[7:4]) + 1;
    er = int'(tb[3:0]) + 1;
    exp_out = byt ? {8'h00, wd[7:0]} : wd;
    ns = 0; na = 0; nr = 0;
    oe_ok = 1; addr_ok = 1; other_ok = 1; busy_ok = 1;
    req_valid = 1'b1; req_dev = dev; req_write = wr; req_byte = byt;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_dev = ~dev; req_addr = ~a; req_wdata = ~wd;
    for (int i = 0; i < 200; i++) begin
      logic s_low, o_low, exp_oe;
      if (ide_cs_n) break;
      s_low = wr ? !ide_diow_n : !ide_dior_n;
      o_low = wr ? !ide_dior_n : !ide_diow_n;
      exp_oe = wr && (s_low || na == 0);
      if (o_low) other_ok = 0;
      if (!busy) busy_ok = 0;
      if (ide_dd_oe !== exp_oe) oe_ok = 0;
      if (exp_oe && ide_dd_out !== exp_out) oe_ok = 0;
      if (ide_addr !== a) addr_ok = 0;
      if (s_low) begin ide_dd_in = base + 16'(na); na++; end
      else if (na == 0) ns++;
      else nr++;
      if (poke && i == 1) begin cfg_we = 1'b1; cfg_addr = pa; cfg_wdata = pv; cfg_wmask = 8'hFF; end
      if (poke && i == 2) begin cfg_we = 1'b0; req_valid = 1'b1; req_dev = dev; end
      if (poke && i == 3) req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0; cfg_we = 1'b0;
    ide_dd_in = 16'hDEAD;
    // R4 phase lengths N+1, R3 set selection
    chk(ns == es, "R4/R3 setup length", ns, es);
    chk(na == ea, "R4/R3 active length", na, ea);
    chk(nr == er, "R4/R3 recovery length", nr, er);
    chk(other_ok, "R4 other strobe stayed high", other_ok, 1);
    chk(addr_ok, "R10 address held", addr_ok, 1);
    chk(oe_ok, "R6 write drive window and data", oe_ok, 1);
    chk(busy_ok, "R7 busy during transfer", busy_ok, 1);
    chk(done === 1'b1 && busy === 1'b0, "R7 done after recovery", {busy, done}, 1);
    if (!wr) begin
      exp_rd = base + 16'(ea - 1);
      if (byt) exp_rd = {8'h00, exp_rd[7:0]};
      chk(rd_data === exp_rd, "R5 read capture on last active clock", rd_data, exp_rd);
    end
    @(negedge clk);
    chk(done === 1'b0, "R7 done single clock", done, 0);
    // R8: a busy-time request must not start a new transfer
    chk(ide_cs_n === 1'b1 && busy === 1'b0, "R8 no restart", {ide_cs_n, busy}, 2);
    if (poke) begin
      slot = model_addr_slot(pa);
      if (slot >= 0) model[slot] = pv;
    end
  endtask

  initial begin
    for (int k = 0; k < 7; k++) model[k] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", {busy, done}, 0);
    chk(ide_cs_n && ide_dior_n && ide_diow_n && !ide_dd_oe, "R1 pins idle after reset",
        {ide_cs_n, ide_dior_n, ide_diow_n, ide_dd_oe}, 4'hE);
    // R1 default timing 0xF everywhere
    run_cycle(0, 0, 0, 3'd1, 16'h0, 16'h1000, 0, 8'h00, 8'h00);
    run_cycle(1, 1, 1, 3'd2, 16'hA55A, 16'h0, 0, 8'h00, 8'h00);
    // R2/R3/R4 sweep over all field values, both devices, all access kinds
    for (int i = 0; i < 16; i++) begin
      for (int d = 0; d < 2; d++) begin
        logic [3:0] iv;
        iv = 4'(i + 5 * d);
        cfg_write(8'h48, {iv, iv}, d ? 8'hF0 : 8'h0F);
        cfg_write(d ? 8'h4E : 8'h4C, {iv, 4'(15 - i)}, 8'hFF);
        cfg_write(d ? 8'h4F : 8'h4D, {4'(i + 3), 4'(i * 5)}, 8'hFF);
        cfg_write(d ? 8'h51 : 8'h50, {4'(i * 7), 4'(i + 9)}, 8'hFF);
        run_cycle(d[0], 0, 0, 3'(i), 16'h0, 16'(i * 256 + 16), 0, 8'h00, 8'h00);
        run_cycle(d[0], 1, 0, 3'(i + 1), 16'(16'h1234 + i), 16'h0, 0, 8'h00, 8'h00);
        run_cycle(d[0], 0, 1, 3'(i + 2), 16'h0, 16'(16'hC3F0 + i), 0, 8'h00, 8'h00);
        run_cycle(d[0], 1, 1, 3'(i + 3), 16'(16'hBEEF - i), 16'h0, 0, 8'h00, 8'h00);
      end
    end
    // R2 masked nibble: rewrite only master setup, slave keeps its value
    cfg_write(8'h48, 8'h00, 8'h0F);
    run_cycle(1, 0, 0, 3'd5, 16'h0, 16'h2000, 0, 8'h00, 8'h00);
    run_cycle(0, 0, 0, 3'd5, 16'h0, 16'h2100, 0, 8'h00, 8'h00);
    // R2 unmapped address is ignored
    cfg_write(8'h4A, 8'h00, 8'hFF);
    run_cycle(0, 1, 0, 3'd6, 16'h7777, 16'h0, 0, 8'h00, 8'h00);
    // R9/R8 write and request during a long transfer
    cfg_write(8'h4C, 8'hFF, 8'hFF);
    run_cycle(0, 0, 0, 3'd7, 16'h0, 16'h3000, 1, 8'h4C, 8'h21);
    run_cycle(0, 0, 0, 3'd7, 16'h0, 16'h3100, 0, 8'h00, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule